// File: doc/BRIEF.md
# 5B/4B Symbol Decoder with Self-Synchronizing Descrambler

This block sits on the receive path between the physical-medium symbol interface and an MII-style receive interface. Each 5-bit line symbol arrives with a one-cycle strobe. The block looks the symbol up in reverse in the 4B/5B code table, which yields a scrambled nibble. It then descrambles that nibble with a 17-bit self-synchronizing shift register and presents the resulting nibble together with an error flag. The strobe is the only time base. The block contains no timer of its own, and nothing advances between strobes.

The descrambler needs no agreement with the transmitter about its starting state. The received scrambled bits are what enter the register. After 17 correct bits, the register therefore holds exactly what the far-end scrambler holds, and from then on the output nibbles equal the transmitter's data. A symbol that has no entry in the code table raises the error flag. That symbol period still advances the descrambler, using a fixed substitute nibble.

Top module: `rx_symbol_descrambler`

## Requirements
- R1: While `rst` is high at a clock edge, `rxd` becomes 0, `rx_er` becomes 0 and the descrambler state is loaded with the parameter `SEED`. Both outputs stay 0 until the first strobe.
- R2: `rxd` and `rx_er` change only on the clock edge where `sym_stb` is high, and take their new value one clock after that edge. Without a strobe, both outputs and the descrambler state hold, whatever `sym_code` carries.
- R3: The reverse lookup maps the 16 valid codes, written as bits 4..0, to nibbles as follows: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R4: A strobed code that is not among the 16 valid codes sets `rx_er` to 1 one clock later. A strobed valid code sets `rx_er` to 0.
- R5: Once set, `rx_er` stays high for the whole symbol period, until the next strobe.
- R6: For each looked-up nibble r, bit 0 is processed first. Each output bit is r[i] XOR state bit 13 XOR state bit 16. Then r[i] is shifted into state bit 0, and each other state bit moves up by one.
- R7: Whatever the starting state, once a stream from a matching x^17+x^14+1 scrambler has delivered 17 valid bits, `rxd` equals the transmitter's unscrambled nibble. This holds from the sixth symbol of a stream onward.
- R8: For an invalid code, `rxd` becomes 0 and the nibble 0000 is shifted into the descrambler in place of received data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb | input | 1 | One-cycle strobe marking a new line symbol |
| sym_code | input | 5 | Received 5B line symbol, valid when `sym_stb` is high |
| rxd | output | 4 | Descrambled receive nibble |
| rx_er | output | 1 | Receive error: last strobed symbol had no table entry |

## Verification
A corrupted descrambler state never shows up as a stuck or illegal output. It shows up as wrong nibbles that look plausible, and only for the next 17 bits, which is up to five symbols. After that the register flushes and the output heals itself. The only way to catch a state fault, a wrong tap or a reversed bit order is to compare every nibble from the first symbol against an exact model built from the known seed. Catching a fault late, after resynchronisation, reveals nothing. A lookup fault is different: it gives a wrong nibble straight away, then pollutes the following 17 bits.

// File: rtl/rxsd_pkg.sv
package rxsd_pkg;

    localparam int SYM_W    = 5;
    localparam int NIB_W    = 4;
    localparam int SCR_W    = 17;
    localparam int TAP_NEAR = 13;
    localparam int TAP_FAR  = 16;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [SCR_W-1:0] scr_t;

    // result of the reverse code lookup
    typedef struct packed {
        logic bad;
        nib_t nib;
    } look_t;

    // reverse 4B/5B table; unmapped codes flag bad and yield 0000
    function automatic look_t sym_to_nib(input sym_t code);
        look_t r;
        r.bad = 1'b0;
        unique case (code)
            5'b11110: r.nib = 4'h0;
            5'b01001: r.nib = 4'h1;
            5'b10100: r.nib = 4'h2;
            5'b10101: r.nib = 4'h3;
            5'b01010: r.nib = 4'h4;
            5'b01011: r.nib = 4'h5;
            5'b01110: r.nib = 4'h6;
            5'b01111: r.nib = 4'h7;
            5'b10010: r.nib = 4'h8;
            5'b10011: r.nib = 4'h9;
            5'b10110: r.nib = 4'hA;
            5'b10111: r.nib = 4'hB;
            5'b11010: r.nib = 4'hC;
            5'b11011: r.nib = 4'hD;
            5'b11100: r.nib = 4'hE;
            5'b11101: r.nib = 4'hF;
            default: begin
                r.nib = '0;
                r.bad = 1'b1;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rxsd_lookup.sv
module rxsd_lookup
    import rxsd_pkg::*;
(
    input  sym_t  code,
    output look_t res
);

    always_comb begin
        res = sym_to_nib(code);
    end

endmodule

// File: rtl/rxsd_descrambler.sv
module rxsd_descrambler
    import rxsd_pkg::*;
#(
    parameter scr_t SEED = 17'h1ACE5
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  nib_t din,
    output nib_t dout
);

    scr_t state;
    scr_t chain [NIB_W+1];

    assign chain[0] = state;

    // unrolled bit-serial chain, bit 0 first
    for (genvar i = 0; i < NIB_W; i++) begin : g_bit
        assign dout[i]     = din[i] ^ chain[i][TAP_NEAR] ^ chain[i][TAP_FAR];
        assign chain[i+1]  = {chain[i][SCR_W-2:0], din[i]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else if (adv) begin
            state <= chain[NIB_W];
        end
    end

    // R6: after a step the newest four bits are the inputs in reverse arrival order
    a_r6_shift_in: assert property (@(posedge clk) disable iff (rst)
        adv |=> (state[3:0] == {$past(din[0]), $past(din[1]), $past(din[2]), $past(din[3])}));

    // R6: older bits move up by one nibble
    a_r6_shift_up: assert property (@(posedge clk) disable iff (rst)
        adv |=> (state[SCR_W-1:NIB_W] == $past(state[SCR_W-1-NIB_W:0])));

    // R2: no strobe, no state change
    a_r2_state_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state));

endmodule

// File: rtl/rx_symbol_descrambler.sv
module rx_symbol_descrambler
    import rxsd_pkg::*;
#(
    parameter logic [16:0] SEED = 17'h1ACE5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_stb,
    input  logic [4:0] sym_code,
    output logic [3:0] rxd,
    output logic       rx_er
);

    look_t lk;
    nib_t  plain;

    rxsd_lookup u_lookup (
        .code (sym_code),
        .res  (lk)
    );

    rxsd_descrambler #(.SEED(SEED)) u_descr (
        .clk  (clk),
        .rst  (rst),
        .adv  (sym_stb),
        .din  (lk.nib),
        .dout (plain)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rxd   <= '0;
            rx_er <= 1'b0;
        end else if (sym_stb) begin
            rxd   <= lk.bad ? '0 : plain;
            rx_er <= lk.bad;
        end
    end

    // R2: outputs move only after a strobe
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !sym_stb |=> ($stable(rxd) && $stable(rx_er)));

    // R4: error flag follows the lookup verdict of the strobed symbol
    a_r4_flag: assert property (@(posedge clk) disable iff (rst)
        sym_stb |=> (rx_er == $past(lk.bad)));

    // R5: a raised flag survives until the next strobe
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (rx_er && !sym_stb) |=> rx_er);

    // R8: invalid symbol yields a zero nibble
    a_r8_zero: assert property (@(posedge clk) disable iff (rst)
        (sym_stb && lk.bad) |=> (rxd == 4'h0));

endmodule

// File: tb/rx_symbol_descrambler_tb.sv
module rx_symbol_descrambler_tb;

    localparam logic [16:0] RX_SEED = 17'h1ACE5;
    localparam logic [16:0] TX_SEED = 17'h0F00D;
    localparam int NVEC = 24;
    localparam logic [3:0] TX_DATA [NVEC] = '{
        4'h0, 4'hF, 4'h5, 4'hA, 4'h3, 4'hC, 4'h1, 4'h2,
        4'h4, 4'h8, 4'h7, 4'hE, 4'h6, 4'h9, 4'hB, 4'hD,
        4'h0, 4'h0, 4'hF, 4'hF, 4'h1, 4'h8, 4'h3, 4'hC
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stb = 1'b0;
    logic [4:0] code = '0;
    logic [3:0] rxd;
    logic       rx_er;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [16:0] txs;
    logic [16:0] rxm;

    always #5 clk = ~clk;

    rx_symbol_descrambler #(.SEED(RX_SEED)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .sym_stb  (stb),
        .sym_code (code),
        .rxd      (rxd),
        .rx_er    (rx_er)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] enc(input logic [3:0] d);
        case (d)
            4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001;
            4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
            4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011;
            4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
            4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011;
            4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
            4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011;
            4'hE: enc = 5'b11100; default: enc = 5'b11101;
        endcase
    endfunction

    function automatic bit is_valid(input logic [4:0] c);
        is_valid = 1'b0;
        for (int k = 0; k < 16; k++) if (enc(k[3:0]) == c) is_valid = 1'b1;
    endfunction

    // far-end scrambler: returns scrambled nibble
    task automatic tx_scramble(input logic [3:0] d, output logic [3:0] sc);
        for (int i = 0; i < 4; i++) begin
            sc[i] = d[i] ^ txs[13] ^ txs[16];
            txs   = {txs[15:0], sc[i]};
        end
    endtask

    // receive model from R6
    task automatic rx_model(input logic [3:0] r, output logic [3:0] o);
        for (int i = 0; i < 4; i++) begin
            o[i] = r[i] ^ rxm[13] ^ rxm[16];
            rxm  = {rxm[15:0], r[i]};
        end
    endtask

    task automatic send(input logic [4:0] c);
        @(negedge clk);
        code = c;
        stb  = 1'b1;
        @(negedge clk);
        stb  = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] sc, exp;
        logic [3:0] held;
        int nbad;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 rxd", {1'b0, rxd}, 5'h0);
        chk("R1 rx_er", {4'b0, rx_er}, 5'h0);
        rst = 1'b0;
        code = 5'b00000;
        repeat (2) @(negedge clk);
        chk("R1 rxd idle", {1'b0, rxd}, 5'h0);
        chk("R1 rx_er idle", {4'b0, rx_er}, 5'h0);

        txs = TX_SEED;
        rxm = RX_SEED;

        // table walk: exact model from first symbol, sync after five
        for (int i = 0; i < NVEC; i++) begin
            tx_scramble(TX_DATA[i], sc);
            rx_model(sc, exp);
            send(enc(sc));
            chk("R6 exact", {1'b0, rxd}, {1'b0, exp});
            chk("R4 valid", {4'b0, rx_er}, 5'h0);
            if (i >= 5) chk("R7 sync", {1'b0, rxd}, {1'b0, TX_DATA[i]});
        end

        // R2: no strobe, garbage on the code lines
        held = rxd;
        code = 5'b00000;
        repeat (3) @(negedge clk);
        chk("R2 rxd hold", {1'b0, rxd}, {1'b0, held});
        chk("R2 rx_er hold", {4'b0, rx_er}, 5'h0);

        // R4/R8: every invalid code
        nbad = 0;
        for (int c = 0; c < 32; c++) begin
            if (!is_valid(c[4:0])) begin
                nbad++;
                rx_model(4'h0, exp);
                send(c[4:0]);
                chk("R4 invalid", {4'b0, rx_er}, 5'h1);
                chk("R8 zero", {1'b0, rxd}, 5'h0);
            end
        end
        chk("R4 count", nbad[4:0], 5'd16);

        // R5: flag stays through idle cycles
        code = 5'b11110;
        repeat (4) @(negedge clk);
        chk("R5 sticky", {4'b0, rx_er}, 5'h1);

        // R3: each valid code directly, against the model
        for (int n = 0; n < 16; n++) begin
            rx_model(n[3:0], exp);
            send(enc(n[3:0]));
            chk("R3 lookup", {1'b0, rxd}, {1'b0, exp});
            chk("R4 clear", {4'b0, rx_er}, 5'h0);
        end

        // R7: resync from a disturbed state
        for (int i = 0; i < 10; i++) begin
            tx_scramble(TX_DATA[NVEC-1-i], sc);
            send(enc(sc));
            if (i >= 5) chk("R7 resync", {1'b0, rxd}, {1'b0, TX_DATA[NVEC-1-i]});
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule